// File: doc/BRIEF.md
# Tagged Fully Associative Address Translation Cache

This block keeps a small set of recently used page mappings and turns a virtual page number into a physical frame number. Every stored mapping is searched in parallel. The result of a lookup appears on registered outputs on the clock edge after the request. Each mapping carries the identifier of the process that owns it. A lookup matches only when that identifier equals the current-process register, so mappings from several processes can be held at once without leaking between them.

When a lookup finds no mapping, the block reports a miss fault and does nothing more. Software (or a separate walker) fetches the page-table entry and writes it in through the refill port. The block picks the slot by itself. It uses an existing slot for the same page and process if there is one, otherwise the first free slot, otherwise the slot under a round-robin pointer. A write access to a read-only mapping is reported as a protection fault. For a context switch there are two controls: one empties the whole cache, and the other drops only the valid bits.

Top module: `tlb_cam`

## Requirements
- R1: After a synchronous reset all response outputs are 0, the current-process register is 0, and no slot is valid, so the first lookup misses.
- R2: A lookup presented on one clock edge gives, on the outputs after that edge, rsp_valid=1 and rsp_hit=1 when a valid slot holds the same page number and the current process id. rsp_pfn, rsp_dirty, rsp_refd and rsp_writable then carry the stored values.
- R3: A slot whose process tag differs from the current-process register never hits. The same page number may be held once per process, each with its own frame.
- R4: A lookup that matches no slot gives rsp_valid=1 and rsp_miss=1, with rsp_pfn and all flag outputs 0.
- R5: A write lookup (lk_write=1) that matches a slot whose writable bit is 0 gives rsp_prot=1 and rsp_hit=0, with the payload outputs 0. A read lookup of the same slot hits.
- R6: When lk_valid and wr_en are both high on one edge, the refill is performed and the lookup is dropped (rsp_valid=0 after that edge). The new mapping is visible to the lookup on the next edge.
- R7: A refill whose page number and process id match a valid slot overwrites that slot, so no duplicate arises and no other mapping is evicted.
- R8: A refill with no matching slot goes to the lowest-index invalid slot. When all slots are valid, it goes to the slot under a round-robin pointer that starts at 0 after reset and advances by one (wrapping) on each such eviction only.
- R9: flush_all empties the cache and inval_all clears every valid bit. Either one blocks any refill and lookup on the same edge (no response), and every later lookup misses until a refill is made.
- R10: pid_load writes pid_value into the current-process register. A lookup on the same edge still uses the previous value.
- R11: rsp_valid=1 comes with exactly one of rsp_hit, rsp_miss, rsp_prot. With rsp_valid=0 all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| pid_load | input | 1 | Load the current-process register |
| pid_value | input | PID_W | New current process id |
| wr_en | input | 1 | Refill write |
| wr_vpn | input | VPN_W | Page number of the refilled mapping |
| wr_pid | input | PID_W | Owning process of the refilled mapping |
| wr_pfn | input | PFN_W | Frame number of the refilled mapping |
| wr_dirty | input | 1 | Dirty flag of the mapping |
| wr_refd | input | 1 | Referenced flag of the mapping |
| wr_writable | input | 1 | Writable flag of the mapping |
| flush_all | input | 1 | Empty the whole cache |
| inval_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss fault, refill needed |
| rsp_prot | output | 1 | Write to a read-only mapping |
| rsp_pfn | output | PFN_W | Translated frame number (0 unless hit) |
| rsp_dirty | output | 1 | Stored dirty flag (0 unless hit) |
| rsp_refd | output | 1 | Stored referenced flag (0 unless hit) |
| rsp_writable | output | 1 | Stored writable flag (0 unless hit) |

## Verification
A wrong tag, valid bit or process-register value shows on the first lookup that touches that slot. One edge later it appears as a hit where a miss was due, a miss where a hit was due, or a wrong frame number. A round-robin pointer that moves at the wrong time stays hidden until the cache is full. It then shows as a surviving or vanished mapping on the lookups that follow the next eviction, which is why the bench fills the cache completely and probes the slots both before and after an eviction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Status bits kept per mapping besides the frame number.
  typedef struct packed {
    logic dirty;
    logic refd;
  } tlb_stat_t;
endpackage

// File: rtl/tlb_match.sv
// Parallel key compare over all slots with a lowest-index priority pick.
module tlb_match #(
  parameter int N  = 64,
  parameter int KW = 19,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][KW-1:0] keys,
  input  logic [N-1:0]         vld,
  input  logic [KW-1:0]        probe,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (keys[g] == probe);
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = IW'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/tlb_victim.sv
// Slot choice for a new mapping: first free slot, else round-robin pointer.
module tlb_victim #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  vld,
  input  logic          take,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign idx = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && !any_free) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 11,
  parameter int PFN_W   = 19,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             pid_load,
  input  logic [PID_W-1:0] pid_value,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_dirty,
  input  logic             wr_refd,
  input  logic             wr_writable,
  input  logic             flush_all,
  input  logic             inval_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_prot,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_dirty,
  output logic             rsp_refd,
  output logic             rsp_writable
);
  import tlb_pkg::*;

  localparam int KW = VPN_W + PID_W;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PW = PFN_W + $bits(tlb_stat_t);

  // Tags, valid and writable bits live in flops for the parallel compare.
  logic [ENTRIES-1:0][KW-1:0] key_q;
  logic [ENTRIES-1:0]         vld_q;
  logic [ENTRIES-1:0]         wrt_q;
  // Frame and status payload: written and read by index only.
  logic [PW-1:0]              pay_mem [ENTRIES];
  logic [PID_W-1:0]           pid_q;

  logic          clr_any, wr_go, lk_go;
  logic          lk_match, dup_hit;
  logic [IW-1:0] lk_idx, dup_idx, vic_idx, wr_idx;
  logic          lk_prot;

  assign clr_any = flush_all || inval_all;
  assign wr_go   = wr_en && !clr_any;
  assign lk_go   = lk_valid && !wr_en && !clr_any;

  tlb_match #(.N(ENTRIES), .KW(KW)) u_lk_match (
    .keys (key_q),
    .vld  (vld_q),
    .probe({lk_vpn, pid_q}),
    .hit  (lk_match),
    .idx  (lk_idx)
  );

  tlb_match #(.N(ENTRIES), .KW(KW)) u_dup_match (
    .keys (key_q),
    .vld  (vld_q),
    .probe({wr_vpn, wr_pid}),
    .hit  (dup_hit),
    .idx  (dup_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk (clk),
    .rst (rst),
    .vld (vld_q),
    .take(wr_go && !dup_hit),
    .idx (vic_idx)
  );

  assign wr_idx  = dup_hit ? dup_idx : vic_idx;
  assign lk_prot = lk_write && !wrt_q[lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      vld_q <= '0;
      wrt_q <= '0;
    end else if (flush_all) begin
      key_q <= '0;
      vld_q <= '0;
      wrt_q <= '0;
    end else if (inval_all) begin
      vld_q <= '0;
    end else if (wr_go) begin
      key_q[wr_idx] <= {wr_vpn, wr_pid};
      vld_q[wr_idx] <= 1'b1;
      wrt_q[wr_idx] <= wr_writable;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) pay_mem[wr_idx] <= {wr_pfn, wr_dirty, wr_refd};
  end

  always_ff @(posedge clk) begin
    if (rst) pid_q <= '0;
    else if (pid_load) pid_q <= pid_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_prot     <= 1'b0;
      rsp_pfn      <= '0;
      rsp_dirty    <= 1'b0;
      rsp_refd     <= 1'b0;
      rsp_writable <= 1'b0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go && lk_match && !lk_prot;
      rsp_miss  <= lk_go && !lk_match;
      rsp_prot  <= lk_go && lk_match && lk_prot;
      if (lk_go && lk_match && !lk_prot) begin
        {rsp_pfn, rsp_dirty, rsp_refd} <= pay_mem[lk_idx];
        rsp_writable <= wrt_q[lk_idx];
      end else begin
        rsp_pfn      <= '0;
        rsp_dirty    <= 1'b0;
        rsp_refd     <= 1'b0;
        rsp_writable <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
  parameter int VPN_W = 11,
  parameter int PFN_W = 19,
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_write,
  input logic             wr_en,
  input logic             flush_all,
  input logic             inval_all,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_prot,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_writable
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot));

  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    armed |-> rsp_valid == $past(lk_valid && !wr_en && !flush_all && !inval_all));

  a_r6_refill_wins: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && wr_en) |=> !rsp_valid);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (flush_all || inval_all) |=> !rsp_valid);

  a_r9_clear_then_miss: assert property (@(posedge clk) disable iff (rst)
    (flush_all || inval_all) ##1 (lk_valid && !wr_en && !flush_all && !inval_all)
    |=> rsp_miss);

  a_r5_prot_on_write: assert property (@(posedge clk) disable iff (rst)
    (armed && rsp_prot) |-> $past(lk_write) && rsp_pfn == '0);

  a_r4_miss_no_payload: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_pfn == '0 && !rsp_writable));
endmodule

bind tlb_cam tlb_cam_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write), .wr_en(wr_en),
  .flush_all(flush_all), .inval_all(inval_all), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
  .rsp_pfn(rsp_pfn), .rsp_writable(rsp_writable)
);

// File: tb/tb_tlb_cam.sv
module tb_tlb_cam;
  localparam int N = 64, VW = 11, FW = 19, PW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, lk_write = 0, pid_load = 0, wr_en = 0;
  logic wr_dirty = 0, wr_refd = 0, wr_writable = 0, flush_all = 0, inval_all = 0;
  logic [VW-1:0] lk_vpn = '0, wr_vpn = '0;
  logic [PW-1:0] pid_value = '0, wr_pid = '0;
  logic [FW-1:0] wr_pfn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_dirty, rsp_refd, rsp_writable;
  logic [FW-1:0] rsp_pfn;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_v[N]; int m_vpn[N]; int m_pid[N]; int m_pfn[N];
  bit m_d[N]; bit m_r[N]; bit m_w[N];
  int m_rr = 0, m_cur = 0;
  bit e_valid, e_hit, e_miss, e_prot, e_d, e_r, e_w; int e_pfn;

  always #2 clk = ~clk;

  tlb_cam #(.ENTRIES(N), .VPN_W(VW), .PFN_W(FW), .PID_W(PW)) dut (.*);

  task automatic compare(string tag);
    checks++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_miss !== e_miss ||
        rsp_prot !== e_prot || rsp_pfn !== FW'(e_pfn) || rsp_dirty !== e_d ||
        rsp_refd !== e_r || rsp_writable !== e_w) begin
      errors++;
      $display("FAIL %s: got v%0b h%0b m%0b p%0b pfn=%0h d%0b r%0b w%0b, exp v%0b h%0b m%0b p%0b pfn=%0h d%0b r%0b w%0b",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_pfn, rsp_dirty, rsp_refd,
               rsp_writable, e_valid, e_hit, e_miss, e_prot, e_pfn, e_d, e_r, e_w);
    end
  endtask

  // One clock: predict, update the model, advance, compare, return inputs to idle.
  task automatic cycle(string tag);
    int hi = -1, slot = -1;
    e_valid = lk_valid && !wr_en && !flush_all && !inval_all;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_pid[i] == m_cur) hi = i;
    e_hit = 0; e_miss = 0; e_prot = 0; e_pfn = 0; e_d = 0; e_r = 0; e_w = 0;
    if (e_valid) begin
      if (hi < 0) e_miss = 1;
      else if (lk_write && !m_w[hi]) e_prot = 1;
      else begin
        e_hit = 1; e_pfn = m_pfn[hi]; e_d = m_d[hi]; e_r = m_r[hi]; e_w = m_w[hi];
      end
    end
    if (flush_all || inval_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (wr_en) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_v[i] && m_vpn[i] == int'(wr_vpn) && m_pid[i] == int'(wr_pid)) slot = i;
      if (slot < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr; m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1; m_vpn[slot] = int'(wr_vpn); m_pid[slot] = int'(wr_pid);
      m_pfn[slot] = int'(wr_pfn); m_d[slot] = wr_dirty; m_r[slot] = wr_refd;
      m_w[slot] = wr_writable;
    end
    if (pid_load) m_cur = int'(pid_value);
    @(posedge clk); @(negedge clk);
    compare(tag);
    lk_valid = 0; lk_write = 0; wr_en = 0; pid_load = 0; flush_all = 0; inval_all = 0;
  endtask

  task automatic look(int vpn, bit wr, string tag);
    lk_valid = 1; lk_vpn = VW'(vpn); lk_write = wr; cycle(tag);
  endtask

  task automatic fill(int vpn, int pid, int pfn, bit d, bit r, bit w);
    wr_en = 1; wr_vpn = VW'(vpn); wr_pid = PW'(pid); wr_pfn = FW'(pfn);
    wr_dirty = d; wr_refd = r; wr_writable = w;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: outputs are zero after reset
    e_valid = 0; e_hit = 0; e_miss = 0; e_prot = 0; e_pfn = 0; e_d = 0; e_r = 0; e_w = 0;
    compare("R1 reset outputs");
    look(5, 0, "R1 empty after reset");
    look(6, 1, "R4 miss fault");
    // R2 refill then hit with payload
    fill(5, 0, 'h123, 0, 1, 1); cycle("R2 refill idle");
    look(5, 0, "R2 read hit");
    look(5, 1, "R5 write hit on writable");
    // R5 read-only mapping
    fill(7, 0, 'h55, 1, 0, 0); cycle("R5 refill ro");
    look(7, 1, "R5 prot fault");
    look(7, 0, "R5 read hit on ro");
    // R10 pid load; same-edge lookup uses old id
    pid_load = 1; pid_value = 3; look(5, 0, "R10 old pid on load edge");
    look(5, 0, "R3 other pid misses");
    fill(5, 3, 'h777, 1, 1, 1); cycle("R3 refill pid3");
    look(5, 0, "R3 pid3 frame");
    pid_load = 1; pid_value = 0; cycle("R10 pid back");
    look(5, 0, "R3 pid0 frame kept");
    // R6 refill beats a same-edge lookup
    fill(9, 0, 'h909, 0, 0, 1); lk_valid = 1; lk_vpn = 9; cycle("R6 lookup dropped");
    look(9, 0, "R6 visible next edge");
    // R7 overwrite in place
    fill(5, 0, 'h0AA, 1, 1, 1); cycle("R7 overwrite");
    look(5, 0, "R7 new frame");
    look(7, 0, "R7 neighbour intact");
    look(9, 0, "R7 neighbour intact");
    // R9 valid-bit clear and full flush
    inval_all = 1; lk_valid = 1; lk_vpn = 7; cycle("R9 inval drops lookup");
    look(7, 0, "R9 miss after inval");
    fill(11, 0, 'h11, 0, 0, 1); cycle("R9 refill");
    flush_all = 1; fill(12, 0, 'h12, 0, 0, 1); cycle("R9 flush blocks refill");
    look(11, 0, "R9 miss after flush");
    look(12, 0, "R9 blocked refill absent");
    // R8 fill all slots, then round-robin eviction
    for (int i = 0; i < N; i++) begin fill(100 + i, 0, 'h1000 + i, 0, 1, 1); cycle("R8 fill"); end
    for (int i = 0; i < N; i++) look(100 + i, 0, "R8 full hit");
    fill(300, 0, 'h3000, 0, 0, 1); cycle("R8 evict 1");
    look(100, 0, "R8 slot0 evicted");
    look(101, 0, "R8 slot1 kept");
    look(300, 0, "R8 new mapping");
    fill(301, 0, 'h3001, 0, 0, 1); cycle("R8 evict 2");
    look(101, 0, "R8 slot1 evicted");
    look(102, 0, "R8 slot2 kept");
    // R8 free slots win over the pointer
    inval_all = 1; cycle("R9 inval");
    for (int i = 0; i < N; i++) begin fill(500 + i, 0, 'h5000 + i, 1, 0, 1); cycle("R8 refill"); end
    fill(600, 0, 'h6000, 0, 0, 1); cycle("R8 evict at pointer 2");
    look(500, 0, "R8 slot0 kept");
    look(502, 0, "R8 slot2 evicted");
    look(600, 1, "R8 new mapping write hit");
    look(563, 0, "R8 last slot kept");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule